// File: doc/BRIEF.md
# Parity-Split Fault-Tolerant Prefix Adder

This block is a parallel-prefix adder, 64 bits wide by default, whose carry network is built twice. One copy serves the sum positions with an even index and the other serves the odd positions. The two copies share no node, so a manufacturing defect that lands inside one copy can only spoil the sum bits of that parity. A chip with such a defect can still be shipped: a two-bit configuration input names the damaged parity, and the adder then finishes every addition using only the healthy copy.

In normal operation one addition is accepted and completed per clock. In degraded operation each addition takes two cycles at the same clock rate. The first cycle writes the healthy-parity bits of the result register. The second cycle moves both operands one position towards the most significant bit, with the carry-in filling the vacated bottom bit. This places each missing bit on a position of the healthy parity, and the healthy copy computes the remaining bits. A fault-forcing input can pin chosen prefix nodes of either copy to a fixed value, so a bench can show both the damage in normal operation and the recovery in degraded operation.

Internally the adder is two positions wider than the operands. The carry-out is treated as result position W (even for W = 64), and one spare position above it lets the shifted pass still reach that position.

Top module: `split_prefix_adder`

## Requirements
- R1: A fault forced into the even-position carry tree (fi_tree = 0) changes only even-indexed bits of the word {carry_out, sum_out}, and a fault in the odd tree (fi_tree = 1) changes only odd-indexed bits. Bit k of sum_out has index k, and carry_out has index W.
- R2: With cfg_mode = 00 at acceptance, {carry_out, sum_out} equals op_a + op_b + carry_in. out_valid is high in the cycle after acceptance, in_ready stays high, and one operand pair can be accepted every cycle.
- R3: cfg_mode = 01 (even tree defective) or 10 (odd tree defective) at acceptance makes the addition take two cycles. In the cycle after acceptance in_ready and out_valid are low. In the following cycle out_valid is high and in_ready is high again.
- R4: After the first degraded cycle, the healthy-parity positions of {carry_out, sum_out} already hold their final values, and the positions of the defective parity still hold their previous contents.
- R5: In the second degraded cycle, both operands are shifted left by one with carry_in placed in bit 0 and the adder's own carry-in held at 0. The positions of the defective parity are then filled from the healthy tree. The final result equals op_a + op_b + carry_in for any set of forced nodes that lies entirely in the defective tree.
- R6: carry_out is written in the cycle that produces index W. For W = 64 that is the first cycle in mode 10 and the second cycle in mode 01.
- R7: cfg_mode is read only when an operand pair is accepted. A change during the second degraded cycle has no effect on the addition in progress, and the code 11 behaves exactly like 00.
- R8: After a synchronous reset, in_ready is 1 and out_valid, sum_out and carry_out are 0.
- R9: Each fault-forcing field has a fixed meaning. fi_en enables forcing. fi_tree picks the tree. fi_level picks the stage: 0 is the per-bit generate signal, and k >= 1 is prefix stage k, which spans 2^k bits. fi_mask picks the columns of the W+2-bit internal word. fi_val is the forced value. When fi_en = 0 these inputs have no effect, and when fi_en = 1 they can corrupt a normal-mode result.
- R10: in_valid and the operand inputs are ignored while in_ready is low. A pair offered during the second degraded cycle is neither taken nor reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Adder can accept a pair this cycle |
| op_a | input | W | First operand |
| op_b | input | W | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| cfg_mode | input | 2 | 00/11 normal, 01 even tree defective, 10 odd tree defective |
| out_valid | output | 1 | One-cycle pulse: result register holds a completed sum |
| sum_out | output | W | Result register, low W bits |
| carry_out | output | 1 | Result register, carry-out |
| fi_en | input | 1 | Enable fault forcing |
| fi_tree | input | 1 | Tree to force: 0 even, 1 odd |
| fi_level | input | 4 | Prefix stage to force (0 = generate inputs) |
| fi_mask | input | W+2 | Columns to force |
| fi_val | input | 1 | Forced value |

## Verification
A six-bit copy of the adder is swept over every operand pair and carry-in in normal mode and in both degraded modes. The degraded sweeps keep a fault active in the defective tree, with its stage, columns and value changing from vector to vector. During each second cycle the sweep also changes cfg_mode and offers a different pair, which separates correct recovery from a late mode read or a wrongly accepted pair. The value seen after each first degraded cycle is compared with the new healthy-parity bits merged over the old register contents, which exposes wrong write masks and a misplaced carry-out. A separate sweep over every single-node fault in normal mode checks that only the faulted parity can change. A 64-bit copy repeats the key cases with an all-ones operand, where one stuck generate signal ripples through every carry of its parity, and with pseudo-random operands under multi-column faults.

// File: rtl/spa_pkg.sv
package spa_pkg;

    localparam int unsigned LEVEL_BITS = 4;

    typedef enum logic [1:0] {
        MODE_FULL     = 2'b00,
        MODE_EVEN_BAD = 2'b01,
        MODE_ODD_BAD  = 2'b10,
        MODE_FULL_ALT = 2'b11
    } spa_mode_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SHIFT = 1'b1
    } spa_state_e;

    // Fault-forcing controls shared by both trees
    typedef struct packed {
        logic                  en;
        logic                  tree;
        logic [LEVEL_BITS-1:0] level;
        logic                  val;
    } spa_fault_t;

    // Per-cycle write plan for the result register
    typedef struct packed {
        logic wr_even;
        logic wr_odd;
        logic from_shift;
        logic done;
    } spa_wr_t;

    function automatic logic mode_degraded(spa_mode_e m);
        return (m == MODE_EVEN_BAD) || (m == MODE_ODD_BAD);
    endfunction

    // Odd tree is the healthy one only when the even tree is declared bad
    function automatic logic mode_odd_healthy(spa_mode_e m);
        return m == MODE_EVEN_BAD;
    endfunction

endpackage

// File: rtl/spa_prefix_tree.sv
module spa_prefix_tree
    import spa_pkg::*;
#(
    parameter int unsigned N = 66
) (
    input  logic [N-1:0] gen_in,
    input  logic [N-1:0] prop_in,
    input  spa_fault_t   flt,
    input  logic [N-1:0] flt_mask,
    output logic [N-1:0] grp_gen
);
    localparam int unsigned LV = $clog2(N);

    logic [LV:0][N-1:0]   gl;
    logic [LV-1:0][N-1:0] pl;

    always_comb begin
        int d;
        int j;
        gl = '0;
        pl = '0;
        for (int i = 0; i < N; i++) begin
            gl[0][i] = (flt.en && flt.level == '0 && flt_mask[i]) ? flt.val : gen_in[i];
            pl[0][i] = prop_in[i];
        end
        for (int k = 1; k <= LV; k++) begin
            d = 1 << (k - 1);
            for (int i = 0; i < N; i++) begin
                j = (i >= d) ? i - d : i;
                if (i >= d) begin
                    gl[k][i] = gl[k-1][i] | (pl[k-1][i] & gl[k-1][j]);
                end else begin
                    gl[k][i] = gl[k-1][i];
                end
                if (k < LV) begin
                    pl[k][i] = (i >= d) ? (pl[k-1][i] & pl[k-1][j]) : pl[k-1][i];
                end
                if (flt.en && flt.level == LEVEL_BITS'(k) && flt_mask[i]) begin
                    gl[k][i] = flt.val;
                end
            end
        end
        grp_gen = gl[LV];
    end

endmodule

// File: rtl/spa_datapath.sv
module spa_datapath
    import spa_pkg::*;
#(
    parameter int unsigned N = 66
) (
    input  logic [N-1:0] add_a,
    input  logic [N-1:0] add_b,
    input  logic         add_cin,
    input  spa_fault_t   flt,
    input  logic [N-1:0] flt_mask,
    output logic [N-1:0] sum
);
    logic [N-1:0] gen, prop, c_even, c_odd;
    spa_fault_t   flt_even, flt_odd;

    always_comb begin
        gen     = add_a & add_b;
        prop    = add_a ^ add_b;
        gen[0]  = gen[0] | (prop[0] & add_cin);
    end

    always_comb begin
        flt_even    = flt;
        flt_even.en = flt.en && !flt.tree;
        flt_odd     = flt;
        flt_odd.en  = flt.en && flt.tree;
    end

    // Two disjoint carry networks, one per sum parity
    spa_prefix_tree #(.N(N)) u_tree_even (
        .gen_in(gen), .prop_in(prop), .flt(flt_even), .flt_mask(flt_mask), .grp_gen(c_even)
    );
    spa_prefix_tree #(.N(N)) u_tree_odd (
        .gen_in(gen), .prop_in(prop), .flt(flt_odd), .flt_mask(flt_mask), .grp_gen(c_odd)
    );

    always_comb begin
        sum[0] = prop[0] ^ add_cin;
        for (int i = 1; i < N; i++) begin
            sum[i] = prop[i] ^ (((i % 2) == 0) ? c_even[i-1] : c_odd[i-1]);
        end
    end

endmodule

// File: rtl/spa_seq.sv
module spa_seq
    import spa_pkg::*;
#(
    parameter int unsigned W = 64,
    parameter int unsigned N = W + 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [1:0]   cfg_mode,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         carry_in,
    output logic         in_ready,
    output logic [N-1:0] add_a,
    output logic [N-1:0] add_b,
    output logic         add_cin,
    output spa_wr_t      wr
);
    spa_state_e   st;
    spa_mode_e    mode_now;
    logic [W-1:0] a_q, b_q;
    logic         c_q, hodd_q, accept, deg_now;

    assign mode_now = spa_mode_e'(cfg_mode);
    assign deg_now  = mode_degraded(mode_now);
    assign in_ready = (st == ST_IDLE);
    assign accept   = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            a_q    <= '0;
            b_q    <= '0;
            c_q    <= 1'b0;
            hodd_q <= 1'b0;
        end else if (accept) begin
            a_q    <= op_a;
            b_q    <= op_b;
            c_q    <= carry_in;
            hodd_q <= mode_odd_healthy(mode_now);
            if (deg_now) begin
                st <= ST_SHIFT;
            end
        end else if (st == ST_SHIFT) begin
            st <= ST_IDLE;
        end
    end

    always_comb begin
        if (st == ST_SHIFT) begin
            // Shifted pass: carry-in enters as a generating bottom bit
            add_a         = {1'b0, a_q, c_q};
            add_b         = {1'b0, b_q, c_q};
            add_cin       = 1'b0;
            wr.wr_even    = hodd_q;
            wr.wr_odd     = !hodd_q;
            wr.from_shift = 1'b1;
            wr.done       = 1'b1;
        end else begin
            add_a         = {2'b00, op_a};
            add_b         = {2'b00, op_b};
            add_cin       = carry_in;
            wr.wr_even    = accept && (!deg_now || !mode_odd_healthy(mode_now));
            wr.wr_odd     = accept && (!deg_now || mode_odd_healthy(mode_now));
            wr.from_shift = 1'b0;
            wr.done       = accept && !deg_now;
        end
    end

endmodule

// File: rtl/spa_result.sv
module spa_result
    import spa_pkg::*;
#(
    parameter int unsigned W = 64,
    parameter int unsigned N = W + 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] sum,
    input  spa_wr_t      wr,
    output logic [W-1:0] sum_out,
    output logic         carry_out,
    output logic         out_valid
);
    logic [W:0] acc, cand, odd_m;

    always_comb begin
        for (int j = 0; j <= W; j++) begin
            cand[j]  = wr.from_shift ? sum[j+1] : sum[j];
            odd_m[j] = ((j % 2) == 1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc       <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= wr.done;
            for (int j = 0; j <= W; j++) begin
                if (((j % 2) == 0) ? wr.wr_even : wr.wr_odd) begin
                    acc[j] <= cand[j];
                end
            end
        end
    end

    assign sum_out   = acc[W-1:0];
    assign carry_out = acc[W];

    AST_EVEN_ONLY_HOLDS_ODD: assert property (@(posedge clk) disable iff (rst)
        (wr.wr_even && !wr.wr_odd) |=> $stable(acc & odd_m)); // R4
    AST_ODD_ONLY_HOLDS_EVEN: assert property (@(posedge clk) disable iff (rst)
        (wr.wr_odd && !wr.wr_even) |=> $stable(acc & ~odd_m)); // R4

endmodule

// File: rtl/split_prefix_adder.sv
module split_prefix_adder
    import spa_pkg::*;
#(
    parameter int unsigned W = 64
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [W-1:0]          op_a,
    input  logic [W-1:0]          op_b,
    input  logic                  carry_in,
    input  logic [1:0]            cfg_mode,
    output logic                  out_valid,
    output logic [W-1:0]          sum_out,
    output logic                  carry_out,
    input  logic                  fi_en,
    input  logic                  fi_tree,
    input  logic [LEVEL_BITS-1:0] fi_level,
    input  logic [W+1:0]          fi_mask,
    input  logic                  fi_val
);
    localparam int unsigned N = W + 2;

    logic [N-1:0] add_a, add_b, dp_sum, ref_sum, odd_pos;
    logic         add_cin;
    spa_wr_t      wr;
    spa_fault_t   flt;

    assign flt = '{en: fi_en, tree: fi_tree, level: fi_level, val: fi_val};

    spa_seq #(.W(W), .N(N)) u_seq (
        .clk(clk), .rst(rst), .in_valid(in_valid), .cfg_mode(cfg_mode),
        .op_a(op_a), .op_b(op_b), .carry_in(carry_in), .in_ready(in_ready),
        .add_a(add_a), .add_b(add_b), .add_cin(add_cin), .wr(wr)
    );

    spa_datapath #(.N(N)) u_dp (
        .add_a(add_a), .add_b(add_b), .add_cin(add_cin),
        .flt(flt), .flt_mask(fi_mask), .sum(dp_sum)
    );

    spa_result #(.W(W), .N(N)) u_res (
        .clk(clk), .rst(rst), .sum(dp_sum), .wr(wr),
        .sum_out(sum_out), .carry_out(carry_out), .out_valid(out_valid)
    );

    // Arithmetic reference for the assertions only
    assign ref_sum = add_a + add_b + N'(add_cin);
    always_comb begin
        for (int i = 0; i < N; i++) begin
            odd_pos[i] = ((i % 2) == 1);
        end
    end

    AST_SUM_MATCHES_ARITH: assert property (@(posedge clk) disable iff (rst)
        !fi_en |-> (dp_sum == ref_sum)); // R9
    AST_EVEN_FAULT_SPARES_ODD: assert property (@(posedge clk) disable iff (rst)
        (fi_en && !fi_tree) |-> (((dp_sum ^ ref_sum) & odd_pos) == '0)); // R1
    AST_ODD_FAULT_SPARES_EVEN: assert property (@(posedge clk) disable iff (rst)
        (fi_en && fi_tree) |-> (((dp_sum ^ ref_sum) & ~odd_pos) == '0)); // R1
    AST_NORMAL_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && (cfg_mode == 2'b00 || cfg_mode == 2'b11)) |=> (out_valid && in_ready)); // R2
    AST_DEGRADED_TWO_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && (cfg_mode == 2'b01 || cfg_mode == 2'b10))
        |=> (!out_valid && !in_ready) ##1 (out_valid && in_ready)); // R3
    AST_BUSY_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        !in_ready |=> in_ready); // R10

endmodule

// File: tb/split_prefix_adder_bench.sv
module split_prefix_adder_bench;

    localparam int SW = 6;
    localparam int BW = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int corrupt_seen = 0;

    // Small instance for exhaustive sweeps
    logic          s_valid = 0, s_ready, s_cin = 0, s_ov, s_cout;
    logic [1:0]    s_mode = 0;
    logic [SW-1:0] s_a = 0, s_b = 0, s_res;
    logic          s_fen = 0, s_ftree = 0, s_fval = 0;
    logic [3:0]    s_flev = 0;
    logic [SW+1:0] s_fmask = 0;
    logic [SW:0]   s_last = 0;

    // Full-width instance for directed cases
    logic          b_valid = 0, b_ready, b_cin = 0, b_ov, b_cout;
    logic [1:0]    b_mode = 0;
    logic [BW-1:0] b_a = 0, b_b = 0, b_res;
    logic          b_fen = 0, b_ftree = 0, b_fval = 0;
    logic [3:0]    b_flev = 0;
    logic [BW+1:0] b_fmask = 0;

    split_prefix_adder #(.W(SW)) u_split_prefix_adder (
        .clk(clk), .rst(rst), .in_valid(s_valid), .in_ready(s_ready),
        .op_a(s_a), .op_b(s_b), .carry_in(s_cin), .cfg_mode(s_mode),
        .out_valid(s_ov), .sum_out(s_res), .carry_out(s_cout),
        .fi_en(s_fen), .fi_tree(s_ftree), .fi_level(s_flev), .fi_mask(s_fmask), .fi_val(s_fval)
    );

    split_prefix_adder #(.W(BW)) u_split_prefix_adder_wide (
        .clk(clk), .rst(rst), .in_valid(b_valid), .in_ready(b_ready),
        .op_a(b_a), .op_b(b_b), .carry_in(b_cin), .cfg_mode(b_mode),
        .out_valid(b_ov), .sum_out(b_res), .carry_out(b_cout),
        .fi_en(b_fen), .fi_tree(b_ftree), .fi_level(b_flev), .fi_mask(b_fmask), .fi_val(b_fval)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [SW:0] par_s(input bit odd);
        logic [SW:0] m;
        for (int i = 0; i <= SW; i++) m[i] = ((i % 2) == 1) == odd;
        return m;
    endfunction

    function automatic logic [BW:0] par_b(input bit odd);
        logic [BW:0] m;
        for (int i = 0; i <= BW; i++) m[i] = ((i % 2) == 1) == odd;
        return m;
    endfunction

    function automatic logic [63:0] xs(input logic [63:0] x);
        logic [63:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 7);
        y = y ^ (y << 17);
        return y;
    endfunction

    // One addition on the small instance, with timing and first-cycle checks
    task automatic s_run(input logic [SW-1:0] a, input logic [SW-1:0] b, input logic c,
                         input logic [1:0] mode, output logic [SW:0] fin);
        logic        deg;
        logic [SW:0] exp, hm, first;
        deg = (mode == 2'b01) || (mode == 2'b10);
        exp = {1'b0, a} + {1'b0, b} + {{SW{1'b0}}, c};
        hm  = par_s(mode == 2'b01);
        @(negedge clk);
        s_valid = 1'b1; s_a = a; s_b = b; s_cin = c; s_mode = mode;
        @(negedge clk);
        if (!deg) begin
            s_valid = 1'b0;
            chk(s_ov && s_ready, "R2 result one cycle after accept, ready held", {s_ov, s_ready}, 2'b11);
            fin = {s_cout, s_res};
        end else begin
            first = {s_cout, s_res};
            chk(!s_ov && !s_ready, "R3 first degraded cycle busy", {s_ov, s_ready}, 2'b00);
            chk(first == ((exp & hm) | (s_last & ~hm)), "R4 only healthy parity written", first,
                (exp & hm) | (s_last & ~hm));
            chk(first[SW] == ((mode == 2'b10) ? exp[SW] : s_last[SW]), "R6 carry-out cycle",
                first[SW], (mode == 2'b10) ? exp[SW] : s_last[SW]);
            // Disturbance during the second cycle: new mode and a new pair (R7, R10)
            s_mode = 2'b00; s_a = ~a; s_b = b ^ 6'h15; s_cin = ~c;
            @(negedge clk);
            s_valid = 1'b0;
            chk(s_ov && s_ready, "R3 result in second cycle", {s_ov, s_ready}, 2'b11);
            fin = {s_cout, s_res};
        end
        s_last = fin;
    endtask

    task automatic b_run(input logic [BW-1:0] a, input logic [BW-1:0] b, input logic c,
                         input logic [1:0] mode, output logic [BW:0] fin);
        @(negedge clk);
        b_valid = 1'b1; b_a = a; b_b = b; b_cin = c; b_mode = mode;
        @(negedge clk);
        b_valid = 1'b0;
        if (mode == 2'b01 || mode == 2'b10) begin
            @(negedge clk);
        end
        chk(b_ov, "R3 wide result valid", b_ov, 1);
        fin = {b_cout, b_res};
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [SW:0] fin, exp;
        logic [BW:0] bfin, bexp;
        logic [63:0] rnd;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(s_ready && !s_ov && s_res == 0 && !s_cout, "R8 reset state small",
            {s_ready, s_ov, s_cout, s_res}, {1'b1, 8'h0});
        chk(b_ready && !b_ov && b_res == 0 && !b_cout, "R8 reset state wide",
            {b_ready, b_ov, b_cout, b_res}, {1'b1, 66'h0});

        // R2 / R9: exhaustive normal mode, fault fields busy but disabled
        for (int a = 0; a < 64; a++) begin
            for (int b = 0; b < 64; b++) begin
                for (int c = 0; c < 2; c++) begin
                    s_fen = 0; s_ftree = a[0]; s_flev = 4'(b % 4); s_fmask = 8'(a ^ b); s_fval = c[0];
                    s_run(6'(a), 6'(b), c[0], 2'b00, fin);
                    exp = 7'(a + b + c);
                    chk(fin == exp, "R2 R9 normal sum", fin, exp);
                end
            end
        end

        // R7: code 11 acts as normal mode
        for (int a = 0; a < 64; a += 3) begin
            s_run(6'(a), 6'(63 - a), a[0], 2'b11, fin);
            exp = 7'(a + (63 - a) + (a % 2));
            chk(fin == exp, "R7 mode 11 as normal", fin, exp);
        end

        // R5: exhaustive degraded modes, fault active in the defective tree
        for (int m = 1; m <= 2; m++) begin
            for (int a = 0; a < 64; a++) begin
                for (int b = 0; b < 64; b++) begin
                    for (int c = 0; c < 2; c++) begin
                        s_fen = 1; s_ftree = (m == 2);
                        s_flev = 4'(a % 4); s_fmask = {a[3:0], b[3:0]}; s_fval = c[0] ^ b[0];
                        s_run(6'(a), 6'(b), c[0], 2'(m), fin);
                        exp = 7'(a + b + c);
                        chk(fin == exp, "R5 degraded sum with fault", fin, exp);
                    end
                end
            end
        end

        // R10: nothing accepted during the second cycle
        s_fen = 0;
        s_run(6'd45, 6'd27, 1'b1, 2'b01, fin);
        @(negedge clk);
        chk(!s_ov && {s_cout, s_res} == 7'd73, "R10 offered pair during busy ignored",
            {s_ov, s_cout, s_res}, {1'b0, 7'd73});

        // R1 / R9: every single-node fault in normal mode
        for (int t = 0; t < 2; t++) begin
            for (int l = 0; l < 4; l++) begin
                for (int col = 0; col < 8; col++) begin
                    for (int v = 0; v < 2; v++) begin
                        for (int p = 0; p < 4; p++) begin
                            logic [SW-1:0] pa, pb;
                            logic          pc;
                            pa = (p == 2) ? 6'd21 : ((p == 3) ? 6'd0 : 6'd63);
                            pb = (p == 2) ? 6'd42 : 6'd0;
                            pc = (p == 0 || p == 2);
                            s_fen = 1; s_ftree = t[0]; s_flev = 4'(l);
                            s_fmask = 8'(1 << col); s_fval = v[0];
                            s_run(pa, pb, pc, 2'b00, fin);
                            exp = {1'b0, pa} + {1'b0, pb} + {6'd0, pc};
                            if (fin != exp) corrupt_seen++;
                            chk(((fin ^ exp) & par_s(t == 0)) == 0, "R1 fault confined to its parity",
                                fin, exp);
                        end
                    end
                end
            end
        end
        s_fen = 0;
        chk(corrupt_seen > 0, "R9 forced node corrupts normal mode", corrupt_seen, 1);

        // Wide instance: clean normal mode
        rnd = 64'h9E37_79B9_7F4A_7C15;
        for (int i = 0; i < 16; i++) begin
            logic [63:0] x, y;
            rnd = xs(rnd); x = rnd;
            rnd = xs(rnd); y = rnd;
            b_run(x, y, rnd[5], 2'b00, bfin);
            bexp = {1'b0, x} + {1'b0, y} + {64'd0, rnd[5]};
            chk(bfin == bexp, "R2 wide normal sum", bfin, bexp);
        end

        // Stuck generate at column 0 of the even tree, all-ones operand
        b_fen = 1; b_ftree = 0; b_flev = 0; b_fmask = 66'd1; b_fval = 1;
        bexp = {1'b0, {BW{1'b1}}};
        b_run({BW{1'b1}}, '0, 1'b0, 2'b00, bfin);
        chk(bfin != bexp, "R9 wide normal mode shows corruption", bfin, bexp);
        chk(((bfin ^ bexp) & par_b(1'b1)) == 0, "R1 wide odd bits intact", bfin, bexp);
        b_run({BW{1'b1}}, '0, 1'b0, 2'b01, bfin);
        chk(bfin == bexp, "R5 wide even-defective recovers", bfin, bexp);

        // Multi-column faults, each confined to the declared defective tree
        for (int i = 0; i < 24; i++) begin
            logic [63:0] x, y;
            logic [1:0]  m;
            m = (i % 2 == 0) ? 2'b10 : 2'b01;
            rnd = xs(rnd); x = rnd;
            rnd = xs(rnd); y = rnd;
            b_fen = 1; b_ftree = (m == 2'b10); b_flev = 4'(i % 8);
            b_fmask = {rnd[1:0], rnd}; b_fval = rnd[9];
            b_run(x, y, rnd[3], m, bfin);
            bexp = {1'b0, x} + {1'b0, y} + {64'd0, rnd[3]};
            chk(bfin == bexp, "R5 R6 wide degraded sum", bfin, bexp);
        end
        b_fen = 0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule